// File: doc/BRIEF.md
# Power-Down Wake-Up Sequencer

This block decides when a small controller's core clock and oscillator run. From Normal operation the core can ask for Idle or for Stop. In Idle the core clock is gated off and the oscillator keeps running. In Stop the oscillator is disabled as well. A wake event brings the core back to Normal. A wake event is either a reset request or a qualified external interrupt.

Leaving Idle is immediate. Leaving Stop always passes through a timed stabilization phase. In that phase the oscillator is re-enabled and the wait flag is raised, but the core clock stays off until a down-counter expires. A reset wake always waits 2^16 oscillator cycles. An interrupt wake waits the length chosen by a 2-bit select. A wake-cause output tells the core why it resumed, and it keeps that value until the next power-down request.

Top module: `pwr_wake_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, the outputs are core_clk_en=1, osc_en=1, wait_busy=0 and wake_cause=00.
- R2: A `stop_req` accepted in Normal gives core_clk_en=0, osc_en=0 and wait_busy=0 on the next cycle. It clears wake_cause to 00. If `idle_req` and `stop_req` arrive together, Stop wins.
- R3: An `idle_req` accepted in Normal gives core_clk_en=0, osc_en=1 and wait_busy=0 on the next cycle, and clears wake_cause to 00.
- R4: An interrupt line counts as a wake only when its `irq_en` bit is 1 and the line is high for FILT consecutive cycles (default 2). The wake is taken at the edge that ends the FILT-th high cycle. A one-cycle pulse, or a line whose enable bit is 0, has no effect.
- R5: In Idle, `rst_req` or a qualified interrupt returns the block to Normal on the next cycle with no wait. wake_cause becomes 01 for a reset wake and 10 for an interrupt wake. Reset wins when both occur together.
- R6: Leaving Stop always enters a wait phase with osc_en=1, wait_busy=1 and core_clk_en=0. The phase lasts exactly L cycles, after which the block is in Normal.
- R7: A reset wake from Stop uses L=2^16 and sets wake_cause=01. It takes precedence over an interrupt qualified in the same cycle.
- R8: An interrupt wake from Stop sets wake_cause=10. L is chosen by `wait_sel`, sampled at the wake edge: 00 gives 2^8, 01 gives 2^11, 10 gives 2^13 and 11 gives 2^16. Changing `wait_sel` later does not change that wait.
- R9: A `rst_req` during the wait phase restarts it with L=2^16 counted from that edge and sets wake_cause=01. A qualified interrupt during the wait phase has no effect.
- R10: wake_cause keeps its value through Normal operation until the next accepted power-down request.
- R11: In Normal, a `rst_req` in the same cycle as a power-down request blocks that request, and the block stays in Normal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| idle_req | input | 1 | Core request to enter Idle |
| stop_req | input | 1 | Core request to enter Stop |
| rst_req | input | 1 | Synchronous reset wake request |
| irq_in | input | N_IRQ | External interrupt lines, active high |
| irq_en | input | N_IRQ | Per-line wake enable |
| wait_sel | input | 2 | Stabilization length for an interrupt wake |
| core_clk_en | output | 1 | Core clock enable |
| osc_en | output | 1 | Oscillator enable |
| wait_busy | output | 1 | Stabilization wait in progress |
| wake_cause | output | 2 | 00 none, 01 reset, 10 interrupt |

## Verification
The hardest case to reach from the ports is a reset that lands in the middle of an interrupt-started stabilization wait. The stimulus enters Stop and wakes it with a short 2^8 interrupt wait. It then raises `rst_req` 100 cycles into that wait. The check is that Normal arrives exactly 2^16 cycles after the reset edge, with cause 01, and not when the short wait would have ended. A second tricky case is a reset and an interrupt that qualify on the same edge while in Stop. To reach it, the interrupt line is raised one cycle before the reset so that its filter completes on the same edge.

// File: rtl/pwr_wake_seq.sv
module pwr_wake_seq #(
  parameter int N_IRQ   = 4,
  parameter int FILT    = 2,
  parameter int LOG_RST = 16,
  parameter int LOG_S0  = 8,
  parameter int LOG_S1  = 11,
  parameter int LOG_S2  = 13,
  parameter int LOG_S3  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             idle_req,
  input  logic             stop_req,
  input  logic             rst_req,
  input  logic [N_IRQ-1:0] irq_in,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic [1:0]       wait_sel,
  output logic             core_clk_en,
  output logic             osc_en,
  output logic             wait_busy,
  output logic [1:0]       wake_cause
);

  localparam int LOG_A  = (LOG_S0 > LOG_S1) ? LOG_S0 : LOG_S1;
  localparam int LOG_B  = (LOG_S2 > LOG_S3) ? LOG_S2 : LOG_S3;
  localparam int LOG_C  = (LOG_A > LOG_B) ? LOG_A : LOG_B;
  localparam int CW     = (LOG_C > LOG_RST) ? LOG_C : LOG_RST;
  localparam int FW     = (FILT > 1) ? $clog2(FILT) : 1;

  localparam logic [1:0] C_NONE = 2'b00;
  localparam logic [1:0] C_RST  = 2'b01;
  localparam logic [1:0] C_IRQ  = 2'b10;

  typedef enum logic [1:0] {S_NORM, S_IDLE, S_STOP, S_WAIT} st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic [1:0]      cause;
  logic [N_IRQ-1:0] hit_v;
  logic            irq_hit;
  logic [CW-1:0]   rst_len;
  logic [CW-1:0]   irq_len;

  for (genvar i = 0; i < N_IRQ; i++) begin : g_filt
    logic [FW-1:0] fc;
    logic          lvl;
    assign lvl = irq_in[i] & irq_en[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    fc <= '0;
      else if (!lvl)                 fc <= '0;
      else if (fc != FW'(FILT - 1))  fc <= fc + 1'b1;
    end
    assign hit_v[i] = lvl & (fc == FW'(FILT - 1));
  end

  assign irq_hit = |hit_v;
  assign rst_len = {CW{1'b1}} >> (CW - LOG_RST);

  always_comb begin
    case (wait_sel)
      2'd0:    irq_len = {CW{1'b1}} >> (CW - LOG_S0);
      2'd1:    irq_len = {CW{1'b1}} >> (CW - LOG_S1);
      2'd2:    irq_len = {CW{1'b1}} >> (CW - LOG_S2);
      default: irq_len = {CW{1'b1}} >> (CW - LOG_S3);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_NORM;
      cnt   <= '0;
      cause <= C_NONE;
    end else begin
      case (st)
        S_NORM: begin
          if (!rst_req) begin
            if (stop_req) begin
              st    <= S_STOP;
              cause <= C_NONE;
            end else if (idle_req) begin
              st    <= S_IDLE;
              cause <= C_NONE;
            end
          end
        end
        S_IDLE: begin
          if (rst_req) begin
            st    <= S_NORM;
            cause <= C_RST;
          end else if (irq_hit) begin
            st    <= S_NORM;
            cause <= C_IRQ;
          end
        end
        S_STOP: begin
          if (rst_req) begin
            st    <= S_WAIT;
            cnt   <= rst_len;
            cause <= C_RST;
          end else if (irq_hit) begin
            st    <= S_WAIT;
            cnt   <= irq_len;
            cause <= C_IRQ;
          end
        end
        default: begin
          if (rst_req) begin
            cnt   <= rst_len;
            cause <= C_RST;
          end else if (cnt == '0) begin
            st <= S_NORM;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  assign core_clk_en = (st == S_NORM);
  assign osc_en      = (st != S_STOP);
  assign wait_busy   = (st == S_WAIT);
  assign wake_cause  = cause;

endmodule

// File: rtl/pwr_wake_seq_chk.sv
module pwr_wake_seq_chk #(
  parameter int N_IRQ = 4,
  parameter int FILT  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             idle_req,
  input logic             stop_req,
  input logic             rst_req,
  input logic [N_IRQ-1:0] irq_in,
  input logic [N_IRQ-1:0] irq_en,
  input logic             core_clk_en,
  input logic             osc_en,
  input logic             wait_busy,
  input logic [1:0]       wake_cause
);

  logic in_stop, in_idle;
  assign in_stop = !osc_en;
  assign in_idle = osc_en && !core_clk_en && !wait_busy;

  a_r1_reset_outputs: assert property (@(posedge clk)
    !rst_n |=> (core_clk_en && osc_en && !wait_busy && wake_cause == 2'b00));

  a_r2_stop_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en && stop_req && !rst_req) |=> (in_stop && wake_cause == 2'b00));

  a_r3_idle_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en && idle_req && !stop_req && !rst_req) |=> in_idle);

  a_r4_pulse_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (FILT > 1 && in_stop && !rst_req && $rose(|(irq_in & irq_en))) |=> in_stop);

  a_r5_idle_reset_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (in_idle && rst_req) |=> (core_clk_en && wake_cause == 2'b01));

  a_r6_stop_exit_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && !$past(in_stop) == 1'b0 && osc_en == 1'b0) |=> (in_stop || wait_busy));

  a_r6_wait_ends_normal: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wait_busy) |-> (core_clk_en && osc_en));

  a_r7_stop_reset_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (in_stop && rst_req) |=> (wait_busy && wake_cause == 2'b01));

  a_r9_wait_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_busy && rst_req) |=> (wait_busy && wake_cause == 2'b01));

  a_r10_cause_held: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en && !idle_req && !stop_req && !rst_req) |=> $stable(wake_cause));

  a_r11_reset_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (core_clk_en && rst_req) |=> core_clk_en);

endmodule

bind pwr_wake_seq pwr_wake_seq_chk #(.N_IRQ(N_IRQ), .FILT(FILT)) u_chk (
  .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .stop_req(stop_req),
  .rst_req(rst_req), .irq_in(irq_in), .irq_en(irq_en),
  .core_clk_en(core_clk_en), .osc_en(osc_en), .wait_busy(wait_busy),
  .wake_cause(wake_cause)
);

// File: tb/tb_pwr_wake_seq.sv
module tb_pwr_wake_seq;
  localparam int NI = 4;
  localparam logic [4:0] E_NORM0 = 5'b11000;
  localparam logic [4:0] E_IDLE  = 5'b01000;
  localparam logic [4:0] E_STOP  = 5'b00000;
  localparam logic [4:0] E_NORMR = 5'b11001;
  localparam logic [4:0] E_NORMI = 5'b11010;
  localparam logic [4:0] E_WAITR = 5'b01101;
  localparam logic [4:0] E_WAITI = 5'b01110;

  logic clk = 0, rst_n = 0;
  logic idle_req = 0, stop_req = 0, rst_req = 0;
  logic [NI-1:0] irq_in = '0, irq_en = '0;
  logic [1:0] wait_sel = 2'd0;
  logic core_clk_en, osc_en, wait_busy;
  logic [1:0] wake_cause;

  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;

  typedef struct { int at; logic [4:0] v; string rq; } exp_t;
  exp_t q[$];

  pwr_wake_seq #(.N_IRQ(NI)) dut (
    .clk(clk), .rst_n(rst_n), .idle_req(idle_req), .stop_req(stop_req),
    .rst_req(rst_req), .irq_in(irq_in), .irq_en(irq_en), .wait_sel(wait_sel),
    .core_clk_en(core_clk_en), .osc_en(osc_en), .wait_busy(wait_busy),
    .wake_cause(wake_cause)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    logic [4:0] obs;
    obs = {core_clk_en, osc_en, wait_busy, wake_cause};
    while (q.size() > 0 && q[0].at <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (obs !== e.v || e.at != cyc) begin
        fails++;
        $display("FAIL %s cyc=%0d actual=%b expected=%b", e.rq, cyc, obs, e.v);
      end
    end
  end

  task automatic expect_at(int at, logic [4:0] v, string rq);
    exp_t e;
    e.at = at; e.v = v; e.rq = rq;
    q.push_back(e);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_stop(string rq);
    stop_req = 1;
    expect_at(cyc + 1, E_STOP, rq);
    tick(1);
    stop_req = 0;
  endtask

  task automatic irq_wake(logic [1:0] sel, int len, string rq, output int entry);
    wait_sel = sel;
    irq_in[2] = 1;
    entry = cyc + 2;
    expect_at(entry, E_WAITI, rq);
    expect_at(entry + len - 1, E_WAITI, rq);
    expect_at(entry + len, E_NORMI, rq);
    tick(2);
    irq_in[2] = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      if (q.size() != 0) begin
        fails++;
        $display("FAIL pending=%0d actual=0 expected=0", q.size());
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(190000 * 8);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    int e;
    tick(2);
    rst_n = 1;
    expect_at(cyc + 1, E_NORM0, "R1 reset state");
    tick(2);

    // Idle, disabled line, short pulse, then interrupt wake
    idle_req = 1;
    expect_at(cyc + 1, E_IDLE, "R3 idle entry");
    tick(1); idle_req = 0;
    irq_in[0] = 1; irq_en = '0;
    expect_at(cyc + 3, E_IDLE, "R4 disabled line");
    tick(3); irq_in[0] = 0; irq_en = '1;
    irq_in[1] = 1;
    expect_at(cyc + 1, E_IDLE, "R4 one high cycle");
    expect_at(cyc + 2, E_NORMI, "R5 idle irq wake");
    tick(2); irq_in[1] = 0;
    expect_at(cyc + 4, E_NORMI, "R10 cause held");
    tick(5);

    // Idle: reset and interrupt qualify together
    idle_req = 1;
    expect_at(cyc + 1, E_IDLE, "R3 idle entry clears cause");
    tick(1); idle_req = 0;
    irq_in[3] = 1; tick(1);
    rst_req = 1;
    expect_at(cyc + 1, E_NORMR, "R5 reset wins in idle");
    tick(1); rst_req = 0; irq_in[3] = 0;
    tick(2);

    // Reset blocks power-down request
    rst_req = 1; stop_req = 1;
    expect_at(cyc + 1, E_NORMR, "R11 reset blocks stop");
    tick(1); rst_req = 0; stop_req = 0;
    tick(2);

    // Stop wins over idle; glitch ignored; 2^8 wait
    idle_req = 1;
    go_stop("R2 stop beats idle");
    idle_req = 0;
    irq_in[0] = 1; tick(1); irq_in[0] = 0;
    expect_at(cyc + 3, E_STOP, "R4 pulse in stop ignored");
    tick(4);
    irq_wake(2'd0, 256, "R8 sel00 length", e);
    wait_sel = 2'd3;
    tick(e + 256 + 2 - cyc);

    // 2^11 wait with an interrupt inside it
    go_stop("R2 stop entry");
    tick(2);
    irq_wake(2'd1, 2048, "R9 irq in wait ignored", e);
    tick(100);
    irq_in[1] = 1; tick(3); irq_in[1] = 0;
    tick(e + 2048 + 2 - cyc);

    // 2^13 wait
    go_stop("R2 stop entry");
    tick(2);
    irq_wake(2'd2, 8192, "R8 sel10 length", e);
    tick(e + 8192 + 2 - cyc);

    // Reset and interrupt together in Stop
    go_stop("R10 cause cleared by stop");
    tick(2);
    wait_sel = 2'd0;
    irq_in[2] = 1; tick(1);
    rst_req = 1;
    e = cyc + 1;
    expect_at(e, E_WAITR, "R7 reset wins in stop");
    expect_at(e + 65535, E_WAITR, "R7 reset wait length");
    expect_at(e + 65536, E_NORMR, "R6 normal after wait");
    tick(1); rst_req = 0; irq_in[2] = 0;
    tick(e + 65536 + 2 - cyc);

    // Reset restarts an interrupt wait
    go_stop("R2 stop entry");
    tick(2);
    wait_sel = 2'd0;
    irq_in[2] = 1;
    expect_at(cyc + 2, E_WAITI, "R6 irq wait entry");
    tick(2); irq_in[2] = 0;
    tick(100);
    rst_req = 1;
    e = cyc + 1;
    expect_at(e, E_WAITR, "R9 restart cause");
    expect_at(e + 255, E_WAITR, "R9 old end passed");
    expect_at(e + 65535, E_WAITR, "R9 restart length");
    expect_at(e + 65536, E_NORMR, "R9 normal after restart");
    tick(1); rst_req = 0;
    tick(e + 65536 + 2 - cyc);

    go_stop("R10 cause cleared");
    tick(3);
    finish_run();
  end
endmodule